// File: doc/BRIEF.md
# Clock-Synchronous Serial Channel

This block is an 8-bit clock-synchronous serial transmit/receive channel. A single shift register carries both directions at once: each transfer clock moves one bit out on the serial output and pulls one bit in from the serial input. There is no separate holding buffer, so the host reads the received byte from the same data register it wrote. A write to that register starts a transfer when the control register permits one.

The transfer clock comes from one of two sources. In internal mode the block builds it from the system clock, using a prescaler (divide by 1, 8 or 32) and an 8-bit divisor, and drives it on the clock pin. It stops by itself after eight cycles and rests high. In external mode the clock pin is an input, and the channel shifts on every edge that arrives on it. The bit order can be set to LSB first or MSB first. The output pin can be released to high impedance, and in external mode it drives a programmable idle level. A flag is raised when the eighth bit has been received.

Top module: `sync_serial_chan`

## Requirements
- R1: After reset, busy and irq are low, both pin enables are low, sclk_o is high, and the data, control and divisor registers read as zero.
- R2: Register map on addr: 0 is data, 1 is control, 2 is divisor. All three read back as written. Control fields: bit 7 is the idle level and start permit, bit 6 is the clock source (1 means internal), bit 5 is the order (1 means MSB first), bit 3 is the port enable, and bits 1:0 select the prescaler (00 divides by 1, 01 by 8, 1x by 32).
- R3: A data write starts a transfer only when control bits 3 and 7 are both 1. Otherwise it only loads the data register: busy stays low and no clock is produced.
- R4: In internal mode, sclk_o is high at the write edge and toggles every H=(n+1)*P system clocks, where n is the divisor and P is the prescaler ratio. The first toggle is a fall, H clocks after the write edge. After 8 falls and 8 rises it stays high.
- R5: SOUT changes on each falling transfer-clock edge and shows the next bit in the selected order. SIN is sampled on each rising edge. After the transfer, the data register holds the received byte, with the first received bit at bit 0 (LSB first) or at bit 7 (MSB first).
- R6: busy is high from the starting write until the eighth rising edge, where irq is set. Any data write clears irq. busy and irq are never high together.
- R7: In internal mode, sout_oe is low until the first fall and stays high through the transfer. It stays high for one more half period (H clocks) after the eighth rise, then drops.
- R8: A data write while SOUT is in that trailing half period drops sout_oe on the next clock and starts the new transfer.
- R9: sclk_oe equals port enable AND internal mode. In external mode, sout_oe follows the port enable alone.
- R10: In external mode, edges on sclk_i are synchronised and take effect within four system clocks. A rising edge before the first falling edge of a transfer is ignored. The eighth counted rise clears busy and sets irq.
- R11: In external mode the register keeps shifting on further sclk_i edges after the eighth.
- R12: A control write loads bit 7 as the SOUT level only while the synchronised sclk_i is low. In external mode that level is driven on SOUT until the first falling edge of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational) |
| sclk_i | input | 1 | Transfer clock input (external mode) |
| sclk_o | output | 1 | Transfer clock output (internal mode) |
| sclk_oe | output | 1 | Drive enable for the clock pin |
| sout_o | output | 1 | Serial data output |
| sout_oe | output | 1 | Drive enable for the serial output pin |
| sin_i | input | 1 | Serial data input |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Transfer-complete request flag |

## Verification
The hardest case to reach is a data write that lands inside the trailing half period, when SOUT is still driven after the eighth rise. The bench uses a divisor and prescaler that make this window 48 system clocks long. It follows the reference model cycle by cycle into the window and only then issues the write. It then checks that the output enable drops at once, rather than 45 clocks later. A second hard case is the stray rising edge that arrives on the external clock before any falling edge. The bench produces it by raising sclk_i right after the start. Any shift that edge caused would show up as a wrong received byte at the end.

// File: rtl/ssc_pkg.sv
`timescale 1ns/1ps
package ssc_pkg;
    localparam int REG_W = 8;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_DIV  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INT_RUN,
        ST_INT_HOLD,
        ST_EXT_RUN
    } ssc_state_e;

    typedef struct packed {
        logic       idle_lvl;
        logic       int_clk;
        logic       msb_first;
        logic       spare4;
        logic       port_en;
        logic       spare2;
        logic [1:0] psel;
    } ssc_ctrl_t;
endpackage

// File: rtl/ssc_clkgen.sv
`timescale 1ns/1ps
module ssc_clkgen #(
    parameter int DIV_W    = 8,
    parameter int PRE_MID  = 8,
    parameter int PRE_SLOW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [1:0]       psel,
    input  logic [DIV_W-1:0] div,
    output logic             half
);
    localparam int PRE_W = $clog2(PRE_SLOW);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] cnt;
    } gen_t;

    gen_t             gen_d, gen_q;
    logic [PRE_W-1:0] pre_lim;
    logic             tick;

    always_comb begin
        unique case (psel)
            2'b00:   pre_lim = '0;
            2'b01:   pre_lim = PRE_W'(PRE_MID - 1);
            default: pre_lim = PRE_W'(PRE_SLOW - 1);
        endcase
        tick  = run && (gen_q.pre == pre_lim);
        half  = tick && (gen_q.cnt == div);
        gen_d = gen_q;
        if (clr || !run) begin
            gen_d = '0;
        end else begin
            gen_d.pre = tick ? '0 : gen_q.pre + 1'b1;
            if (half)
                gen_d.cnt = '0;
            else if (tick)
                gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gen_q <= '0;
        else
            gen_q <= gen_d;
    end

    // R4: counters rest at zero while the generator is stopped
    a_r4_idle_counters: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (gen_q.pre == '0 && gen_q.cnt == '0));
endmodule

// File: rtl/ssc_edge.sv
`timescale 1ns/1ps
module ssc_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d  = {sh_q[STAGES-1:0], pin};
        level = sh_q[STAGES-1];
        rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
        fall  = ~sh_q[STAGES-1] & sh_q[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sh_q <= '0;
        else
            sh_q <= sh_d;
    end
endmodule

// File: rtl/sync_serial_chan.sv
`timescale 1ns/1ps
module sync_serial_chan
    import ssc_pkg::*;
#(
    parameter int XFER_BITS   = 8,
    parameter int DIV_W       = 8,
    parameter int PRE_MID     = 8,
    parameter int PRE_SLOW    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       sclk_i,
    output logic       sclk_o,
    output logic       sclk_oe,
    output logic       sout_o,
    output logic       sout_oe,
    input  logic       sin_i,
    output logic       busy,
    output logic       irq
);
    localparam int                CNT_W = $clog2(XFER_BITS + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(XFER_BITS - 1);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(XFER_BITS);

    typedef struct packed {
        ssc_state_e       state;
        logic [REG_W-1:0] sr;
        ssc_ctrl_t        ctrl;
        logic [DIV_W-1:0] div;
        logic             sclk;
        logic             sout;
        logic             drv;
        logic             busy;
        logic             irq;
        logic [CNT_W-1:0] rises;
        logic             fall_seen;
    } chan_t;

    chan_t chan_d, chan_q;

    logic data_wr, ctrl_wr, div_wr, start_ok, gen_run, half;
    logic ext_level, ext_rise, ext_fall, out_bit;
    logic [REG_W-1:0] sr_shift;

    assign data_wr  = wr_en && (addr == ADDR_DATA);
    assign ctrl_wr  = wr_en && (addr == ADDR_CTRL);
    assign div_wr   = wr_en && (addr == ADDR_DIV);
    assign start_ok = chan_q.ctrl.port_en && chan_q.ctrl.idle_lvl;
    assign gen_run  = (chan_q.state == ST_INT_RUN) || (chan_q.state == ST_INT_HOLD);

    ssc_clkgen #(
        .DIV_W   (DIV_W),
        .PRE_MID (PRE_MID),
        .PRE_SLOW(PRE_SLOW)
    ) u_clkgen (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (gen_run),
        .clr  (data_wr && start_ok),
        .psel (chan_q.ctrl.psel),
        .div  (chan_q.div),
        .half (half)
    );

    ssc_edge #(
        .STAGES(SYNC_STAGES)
    ) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (sclk_i),
        .level(ext_level),
        .rise (ext_rise),
        .fall (ext_fall)
    );

    always_comb begin
        out_bit  = chan_q.ctrl.msb_first ? chan_q.sr[REG_W-1] : chan_q.sr[0];
        sr_shift = chan_q.ctrl.msb_first ? {chan_q.sr[REG_W-2:0], sin_i}
                                         : {sin_i, chan_q.sr[REG_W-1:1]};
        chan_d = chan_q;

        unique case (chan_q.state)
            ST_INT_RUN: begin
                if (half) begin
                    if (chan_q.sclk) begin
                        chan_d.sclk = 1'b0;
                        chan_d.sout = out_bit;
                        chan_d.drv  = 1'b1;
                    end else begin
                        chan_d.sclk  = 1'b1;
                        chan_d.sr    = sr_shift;
                        chan_d.rises = chan_q.rises + 1'b1;
                        if (chan_q.rises == LAST) begin
                            chan_d.irq   = 1'b1;
                            chan_d.busy  = 1'b0;
                            chan_d.state = ST_INT_HOLD;
                        end
                    end
                end
            end
            ST_INT_HOLD: begin
                if (half) begin
                    chan_d.drv   = 1'b0;
                    chan_d.state = ST_IDLE;
                end
            end
            ST_EXT_RUN: begin
                if (ext_fall) begin
                    chan_d.sout      = out_bit;
                    chan_d.fall_seen = 1'b1;
                end
                if (ext_rise && chan_q.fall_seen) begin
                    chan_d.sr = sr_shift;
                    if (chan_q.rises != FULL)
                        chan_d.rises = chan_q.rises + 1'b1;
                    if (chan_q.rises == LAST) begin
                        chan_d.irq  = 1'b1;
                        chan_d.busy = 1'b0;
                    end
                end
            end
            default: ;
        endcase

        if (ctrl_wr) begin
            chan_d.ctrl = ssc_ctrl_t'(wdata);
            if (!ext_level)
                chan_d.sout = wdata[7];
        end
        if (div_wr)
            chan_d.div = wdata[DIV_W-1:0];
        if (data_wr) begin
            chan_d.sr        = wdata;
            chan_d.irq       = 1'b0;
            chan_d.drv       = 1'b0;
            chan_d.sclk      = 1'b1;
            chan_d.rises     = '0;
            chan_d.fall_seen = 1'b0;
            chan_d.busy      = start_ok;
            if (!start_ok)
                chan_d.state = ST_IDLE;
            else if (chan_q.ctrl.int_clk)
                chan_d.state = ST_INT_RUN;
            else
                chan_d.state = ST_EXT_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q      <= '0;
            chan_q.sclk <= 1'b1;
            chan_q.sout <= 1'b1;
        end else begin
            chan_q <= chan_d;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_DATA: rdata = chan_q.sr;
            ADDR_CTRL: rdata = chan_q.ctrl;
            ADDR_DIV:  rdata[DIV_W-1:0] = chan_q.div;
            default:   rdata = '0;
        endcase
    end

    assign sclk_o  = chan_q.sclk;
    assign sclk_oe = chan_q.ctrl.port_en & chan_q.ctrl.int_clk;
    assign sout_o  = chan_q.sout;
    assign sout_oe = chan_q.ctrl.port_en & (chan_q.ctrl.int_clk ? chan_q.drv : 1'b1);
    assign busy    = chan_q.busy;
    assign irq     = chan_q.irq;

    // R6: completion flag and busy never overlap
    a_r6_busy_irq_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(chan_q.busy && chan_q.irq));

    // R6: flag rises only together with the last counted bit
    a_r6_irq_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chan_q.irq) |-> (chan_q.rises == FULL));

    // R4: the transfer clock moves only on a generator half-period pulse
    a_r4_clk_on_half: assert property (@(posedge clk) disable iff (!rst_n)
        (!half && !data_wr) |=> $stable(chan_q.sclk));

    // R7: the trailing half period ends by releasing SOUT
    a_r7_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_q.state == ST_INT_HOLD && half && !data_wr) |=> !chan_q.drv);

    // R12: a control write with the clock input high leaves the SOUT level alone
    a_r12_idle_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ext_level && chan_q.state != ST_INT_RUN) |=> $stable(chan_q.sout));

    // R10: the bit counter never passes the transfer length
    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        chan_q.rises <= FULL);
endmodule

// File: tb/sim_sync_serial_chan.sv
`timescale 1ns/1ps
module sim_sync_serial_chan;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       sclk_i, sclk_o, sclk_oe, sout_o, sout_oe, sin_i, busy, irq;

    int checks = 0;
    int errors = 0;
    int H = 1;
    logic [7:0] tx, rx;
    logic       msb;

    always #2 clk = ~clk;

    sync_serial_chan u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
        .sout_o(sout_o), .sout_oe(sout_oe), .sin_i(sin_i), .busy(busy), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); addr = a;
        #1 v = rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic pick(input logic [7:0] v, input int i);
        return msb ? v[7-i] : v[i];
    endfunction

    // behavioural model of one internal-clock transfer, t counted from the write edge
    task automatic track_int(input int ncyc);
        for (int t = 0; t < ncyc; t++) begin
            int e = t / H;
            if (e > 17) e = 17;
            chk("R4", "sclk_o", {7'd0, sclk_o}, (e >= 16 || e % 2 == 0) ? 8'd1 : 8'd0);
            chk("R7", "sout_oe", {7'd0, sout_oe}, (e >= 1 && e < 17) ? 8'd1 : 8'd0);
            chk("R6", "busy", {7'd0, busy}, (e < 16) ? 8'd1 : 8'd0);
            chk("R6", "irq", {7'd0, irq}, (e >= 16) ? 8'd1 : 8'd0);
            if (e >= 1 && e <= 16)
                chk("R5", "sout_o", {7'd0, sout_o}, {7'd0, pick(tx, (e - 1) / 2)});
            if (e / 2 < 8)
                sin_i = pick(rx, e / 2);
            @(negedge clk);
        end
    endtask

    task automatic run_int(input logic [7:0] ctrl, input logic [7:0] n, input int hp,
                           input logic [7:0] txv, input logic [7:0] rxv);
        logic [7:0] v;
        H = hp; tx = txv; rx = rxv; msb = ctrl[5];
        host_wr(2'd2, n);
        host_wr(2'd1, ctrl);
        host_wr(2'd0, tx);
        track_int(17 * H + 3);
        host_rd(2'd0, v);
        chk("R5", "received byte", v, rx);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst_n = 1'b0; wr_en = 1'b0; addr = 2'd0; wdata = 8'd0; sclk_i = 1'b0; sin_i = 1'b0;
        msb = 1'b0; tx = 8'd0; rx = 8'd0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        chk("R1", "busy", {7'd0, busy}, 8'd0);
        chk("R1", "irq", {7'd0, irq}, 8'd0);
        chk("R1", "sclk_oe", {7'd0, sclk_oe}, 8'd0);
        chk("R1", "sout_oe", {7'd0, sout_oe}, 8'd0);
        chk("R1", "sclk_o", {7'd0, sclk_o}, 8'd1);
        host_rd(2'd0, v); chk("R1", "data reg", v, 8'h00);
        host_rd(2'd1, v); chk("R1", "ctrl reg", v, 8'h00);
        host_rd(2'd2, v); chk("R1", "div reg", v, 8'h00);

        host_wr(2'd2, 8'h5A);
        host_rd(2'd2, v); chk("R2", "div readback", v, 8'h5A);

        // external mode: idle level and pin enables
        host_wr(2'd1, 8'h88);
        wait_cyc(2);
        chk("R9", "sclk_oe ext", {7'd0, sclk_oe}, 8'd0);
        chk("R9", "sout_oe ext", {7'd0, sout_oe}, 8'd1);
        chk("R12", "idle level 1", {7'd0, sout_o}, 8'd1);
        sclk_i = 1'b1; wait_cyc(5);
        host_wr(2'd1, 8'h08);
        chk("R12", "level kept while clk high", {7'd0, sout_o}, 8'd1);
        host_rd(2'd1, v); chk("R2", "ctrl readback", v, 8'h08);
        sclk_i = 1'b0; wait_cyc(5);
        host_wr(2'd1, 8'h08);
        chk("R12", "level loaded while clk low", {7'd0, sout_o}, 8'd0);
        host_wr(2'd1, 8'h88);
        chk("R12", "level back to 1", {7'd0, sout_o}, 8'd1);

        // external transfer, LSB first
        msb = 1'b0; tx = 8'h3B; rx = 8'hC6;
        host_wr(2'd0, tx);
        chk("R6", "busy at start ext", {7'd0, busy}, 8'd1);
        sclk_i = 1'b1; wait_cyc(5);
        chk("R12", "idle level before first fall", {7'd0, sout_o}, 8'd1);
        for (int k = 0; k < 8; k++) begin
            sclk_i = 1'b0; wait_cyc(5);
            chk("R10", "sout after ext fall", {7'd0, sout_o}, {7'd0, tx[k]});
            sin_i = rx[k];
            sclk_i = 1'b1; wait_cyc(5);
            if (k < 7) chk("R10", "busy mid ext", {7'd0, busy}, 8'd1);
        end
        chk("R10", "busy done ext", {7'd0, busy}, 8'd0);
        chk("R10", "irq done ext", {7'd0, irq}, 8'd1);
        host_rd(2'd0, v); chk("R10", "ext received byte", v, rx);
        sclk_i = 1'b0; wait_cyc(5);
        chk("R11", "sout on ninth fall", {7'd0, sout_o}, {7'd0, rx[0]});
        sin_i = 1'b1;
        sclk_i = 1'b1; wait_cyc(5);
        host_rd(2'd0, v); chk("R11", "shift past eight", v, {1'b1, rx[7:1]});
        chk("R11", "irq held", {7'd0, irq}, 8'd1);
        sclk_i = 1'b0; wait_cyc(5);

        // no start without idle-level bit
        host_wr(2'd1, 8'h48);
        host_wr(2'd0, 8'h77);
        chk("R6", "irq cleared by write", {7'd0, irq}, 8'd0);
        for (int i = 0; i < 10; i++) begin
            chk("R3", "busy stays low", {7'd0, busy}, 8'd0);
            chk("R3", "no clock", {7'd0, sclk_o}, 8'd1);
            wait_cyc(1);
        end
        chk("R3", "sout not driven", {7'd0, sout_oe}, 8'd0);
        host_rd(2'd0, v); chk("R3", "data loaded", v, 8'h77);

        host_wr(2'd1, 8'hC0);
        chk("R9", "sclk_oe no port", {7'd0, sclk_oe}, 8'd0);
        chk("R9", "sout_oe no port", {7'd0, sout_oe}, 8'd0);
        host_wr(2'd1, 8'hC8);
        chk("R9", "sclk_oe int", {7'd0, sclk_oe}, 8'd1);

        // internal transfers with the cycle model
        run_int(8'hC8, 8'd0, 1, 8'hA5, 8'h3C);
        run_int(8'hE9, 8'd5, 48, 8'h96, 8'hC1);
        run_int(8'hCA, 8'd3, 128, 8'h4E, 8'h81);

        // write inside the trailing half period
        H = 48; tx = 8'h5A; rx = 8'h0F; msb = 1'b0;
        host_wr(2'd2, 8'd5);
        host_wr(2'd1, 8'hC9);
        host_wr(2'd0, tx);
        track_int(16 * H + 1);
        tx = 8'hE3; rx = 8'h72;
        host_wr(2'd0, tx);
        chk("R8", "sout released by write", {7'd0, sout_oe}, 8'd0);
        chk("R8", "new transfer busy", {7'd0, busy}, 8'd1);
        track_int(17 * H + 3);
        host_rd(2'd0, v); chk("R8", "restarted byte", v, rx);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule